// File: doc/BRIEF.md
# Transparent Serial Receiver with Sync Hunt

This block turns a serial bit stream that has no protocol framing into bytes. A bit-clock enable qualifies each incoming bit. After enable the receiver hunts for alignment. It aligns in one of two ways: a strobe on an external sync pin, or a 16-bit programmable pattern seen in the incoming bits. Once aligned it packs bits into bytes, can mirror each byte, and hands the bytes to a downstream consumer. The bytes are grouped into buffers whose length is programmable.

A bit-serial CRC runs over every data bit, and software is free to ignore it. An end-of-frame strobe triggers a residual check. A busy flag reports that bytes were dropped because no buffer was offered. An overrun, which is a byte finishing while the consumer is not ready, is treated as an error and sends the receiver back to hunting. An enter-hunt command does the same.

The byte output is a valid/ready stream with one rule for back-pressure. `m_ready` is sampled in the cycle a byte completes. If it is high, the byte appears with `m_valid` for exactly one cycle on the next clock, and the consumer must take it then. If it is low, the byte is lost and an overrun is reported. `m_valid` is never held waiting for `m_ready`.

Top module: `xparent_rx`

## Requirements
- R1: After reset, `synced`, `m_valid`, `busy`, `busy_irq`, `overrun` and `crc_valid` are all low.
- R2: With `ext_mode`=0 the receiver outputs no byte until the last 16 qualified bits, oldest in bit 15, equal `sync_pattern`. `synced` then goes high. The pattern bits are never output as data, and the first data bit is the next qualified bit.
- R3: With `ext_mode`=1, a qualified bit received together with `sync_pulse` high aligns the receiver, and that same bit is the first data bit.
- R4: Bytes are packed first-bit-first into bit 7. Each byte appears on `m_data` with a one-cycle `m_valid` on the clock after its eighth bit.
- R5: With `reverse`=1, every output byte has its bit order mirrored, so the first received bit lands in bit 0.
- R6: A one-cycle `hunt_cmd` drops `synced` on the next clock. Bits received after that produce no bytes until alignment is reached again.
- R7: The buffer length is `buf_len`, which must be at least 1. Every `buf_len`-th accepted byte, counted across hunts since reset, carries `m_last` and `buf_done`. `buf_irq` pulses with it only while `buf_irq_en` is 1.
- R8: If `buf_avail` is low when a byte completes (with `m_ready` high), the byte is dropped and not counted, and `busy` is set. `busy` stays set until a `busy_clr` pulse clears it. `busy_irq` equals `busy` AND `busy_irq_en`.
- R9: If `m_ready` is low when a byte completes, the byte is dropped, `overrun` pulses on the next clock and `synced` falls at the same time.
- R10: The CRC register starts at zero when alignment is reached. It is updated for each data bit, MSB-first, with no final inversion. `crc_sel`=0 selects polynomial 0x1021 and 1 selects 0x8005. A one-cycle `eof` gives `crc_valid` on the next clock, with `crc_err` high exactly when the register is nonzero, and then clears the register. A frame followed by its own CRC therefore reads clean.
- R11: While `en` is low the receiver is held in hunt, with `synced` low on the clock after `en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receiver enable |
| bit_en | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Serial data |
| ext_mode | input | 1 | 1: align on `sync_pulse`; 0: align on pattern |
| sync_pulse | input | 1 | External alignment strobe |
| sync_pattern | input | 16 | Inline alignment pattern |
| reverse | input | 1 | Mirror bit order of each byte |
| crc_sel | input | 1 | CRC polynomial select |
| hunt_cmd | input | 1 | Enter-hunt command pulse |
| eof | input | 1 | End-of-frame strobe for the CRC check |
| buf_len | input | 8 | Bytes per buffer |
| buf_irq_en | input | 1 | Enable buffer-complete interrupt |
| buf_avail | input | 1 | Next buffer is available |
| busy_clr | input | 1 | Write-one-to-clear for `busy` |
| busy_irq_en | input | 1 | Mask for busy interrupt |
| m_ready | input | 1 | Consumer ready |
| m_valid | output | 1 | Byte valid, one cycle |
| m_data | output | 8 | Byte |
| m_last | output | 1 | Last byte of a buffer |
| synced | output | 1 | Receiver aligned |
| buf_done | output | 1 | Buffer complete pulse |
| buf_irq | output | 1 | Buffer interrupt pulse |
| busy | output | 1 | Bytes dropped for lack of a buffer |
| busy_irq | output | 1 | Masked busy interrupt |
| overrun | output | 1 | Overrun pulse |
| crc_valid | output | 1 | CRC check result valid |
| crc_err | output | 1 | CRC residual nonzero |

## Verification
The assertions rely on `hunt_cmd`, `busy_clr` and `eof` arriving as isolated one-cycle pulses, and on `eof` never coinciding with `bit_en`. The stimulus keeps to this. Every bit is a one-cycle `bit_en` followed by one idle cycle, and control inputs change only on falling edges between bits. The noise sent before an inline pattern is chosen so that it cannot contain the pattern. `buf_len` stays nonzero throughout.

// File: rtl/xrx_pkg.sv
package xrx_pkg;
  typedef enum logic {ST_HUNT = 1'b0, ST_SYNC = 1'b1} rx_state_e;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] POLY_A = 16'h1021;
  localparam logic [CRC_W-1:0] POLY_B = 16'h8005;
endpackage

// File: rtl/xrx_sync_hunt.sv
module xrx_sync_hunt
  import xrx_pkg::*;
#(
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              ext_mode,
  input  logic              sync_pulse,
  input  logic [SYNC_W-1:0] pattern,
  input  logic              hunt_cmd,
  input  logic              err,
  output logic              synced,
  output logic              take,
  output logic              start
);
  rx_state_e st, st_nx;
  logic [SYNC_W-1:0] hist, hist_nx;
  logic pat_hit, pulse_hit;

  assign hist_nx   = {hist[SYNC_W-2:0], bit_in};
  assign pat_hit   = bit_en && !ext_mode && (hist_nx == pattern);
  assign pulse_hit = bit_en && ext_mode && sync_pulse;

  always_comb begin
    st_nx = st;
    if (!en || hunt_cmd || err) st_nx = ST_HUNT;
    else if (st == ST_HUNT && (pat_hit || pulse_hit)) st_nx = ST_SYNC;
  end

  assign take   = en && !hunt_cmd && bit_en &&
                  (st == ST_SYNC || (st == ST_HUNT && pulse_hit));
  assign start  = (st == ST_HUNT) && (st_nx == ST_SYNC);
  assign synced = (st == ST_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_HUNT;
      hist <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_SYNC && st_nx == ST_HUNT) hist <= ~pattern;
      else if (bit_en) hist <= hist_nx;
    end
  end
endmodule

// File: rtl/xrx_deser.sv
module xrx_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              clr,
  input  logic              bit_in,
  input  logic              reverse,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] acc, packed_b, mirrored;

  assign packed_b  = {acc[BYTE_W-2:0], bit_in};
  assign byte_done = take && (cnt == LAST_BIT);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_mirror
    assign mirrored[i] = packed_b[BYTE_W-1-i];
  end

  assign byte_out = reverse ? mirrored : packed_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (take) begin
      acc <= packed_b;
      cnt <= byte_done ? '0 : cnt + 1'b1;
    end else if (clr) begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/xrx_crc.sv
module xrx_crc
  import xrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic start,
  input  logic bit_in,
  input  logic crc_sel,
  input  logic eof,
  output logic crc_valid,
  output logic crc_err
);
  logic [CRC_W-1:0] crc, base, poly, stepped;
  logic fb;

  assign poly    = crc_sel ? POLY_B : POLY_A;
  assign base    = start ? '0 : crc;
  assign fb      = base[CRC_W-1] ^ bit_in;
  assign stepped = {base[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc       <= '0;
      crc_valid <= 1'b0;
      crc_err   <= 1'b0;
    end else begin
      crc_valid <= eof;
      crc_err   <= eof && (crc != '0);
      if (eof) crc <= '0;
      else if (take) crc <= stepped;
      else if (start) crc <= '0;
    end
  end
endmodule

// File: rtl/xparent_rx.sv
module xparent_rx
  import xrx_pkg::*;
#(
  parameter int SYNC_W = 16,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              ext_mode,
  input  logic              sync_pulse,
  input  logic [SYNC_W-1:0] sync_pattern,
  input  logic              reverse,
  input  logic              crc_sel,
  input  logic              hunt_cmd,
  input  logic              eof,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic              buf_irq_en,
  input  logic              buf_avail,
  input  logic              busy_clr,
  input  logic              busy_irq_en,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  output logic              synced,
  output logic              buf_done,
  output logic              buf_irq,
  output logic              busy,
  output logic              busy_irq,
  output logic              overrun,
  output logic              crc_valid,
  output logic              crc_err
);
  logic take, start, byte_done, ovr, keep, drop_busy, last_here;
  logic [BYTE_W-1:0] byte_val;
  logic [LEN_W-1:0]  bcnt;
  logic [LEN_W:0]    bcnt_inc;

  assign ovr       = byte_done && !m_ready;
  assign keep      = byte_done && m_ready && buf_avail;
  assign drop_busy = byte_done && m_ready && !buf_avail;
  assign bcnt_inc  = {1'b0, bcnt} + 1'b1;
  assign last_here = (bcnt_inc == {1'b0, buf_len});

  xrx_sync_hunt #(.SYNC_W(SYNC_W)) u_hunt (
    .clk, .rst_n, .en, .bit_en, .bit_in, .ext_mode, .sync_pulse,
    .pattern(sync_pattern), .hunt_cmd, .err(ovr),
    .synced, .take, .start
  );

  xrx_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk, .rst_n, .take, .clr(!synced), .bit_in, .reverse,
    .byte_done, .byte_out(byte_val)
  );

  xrx_crc u_crc (
    .clk, .rst_n, .take, .start, .bit_in, .crc_sel, .eof,
    .crc_valid, .crc_err
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_data   <= '0;
      m_last   <= 1'b0;
      buf_done <= 1'b0;
      buf_irq  <= 1'b0;
      overrun  <= 1'b0;
      busy     <= 1'b0;
      bcnt     <= '0;
    end else begin
      m_valid  <= keep;
      m_last   <= keep && last_here;
      buf_done <= keep && last_here;
      buf_irq  <= keep && last_here && buf_irq_en;
      overrun  <= ovr;
      if (keep) begin
        m_data <= byte_val;
        bcnt   <= last_here ? '0 : bcnt_inc[LEN_W-1:0];
      end
      if (drop_busy) busy <= 1'b1;
      else if (busy_clr) busy <= 1'b0;
    end
  end

  assign busy_irq = busy && busy_irq_en;
endmodule

// File: rtl/xrx_checker.sv
module xrx_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic hunt_cmd,
  input logic busy_clr,
  input logic synced,
  input logic m_valid,
  input logic m_last,
  input logic buf_done,
  input logic buf_irq,
  input logic busy,
  input logic busy_irq,
  input logic overrun
);
  assert_data_needs_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> $past(synced));
  assert_hunt_cmd_drops_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hunt_cmd) |-> !synced);
  assert_done_with_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> (m_valid && m_last));
  assert_irq_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_irq |-> buf_done);
  assert_busy_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(busy_clr)) |-> busy);
  assert_busy_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_irq |-> busy);
  assert_overrun_hunts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (!synced && !m_valid));
  assert_disable_hunts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !synced);
endmodule

bind xparent_rx xrx_checker u_chk (.*);

// File: tb/tb_xparent_rx.sv
module tb_xparent_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, bit_en = 1'b0, bit_in = 1'b0, ext_mode = 1'b0, sync_pulse = 1'b0;
  logic [15:0] sync_pattern = 16'hA55A;
  logic reverse = 1'b0, crc_sel = 1'b0, hunt_cmd = 1'b0, eof = 1'b0;
  logic [7:0] buf_len = 8'd4;
  logic buf_irq_en = 1'b1, buf_avail = 1'b1, busy_clr = 1'b0, busy_irq_en = 1'b1, m_ready = 1'b1;
  logic m_valid, m_last, synced, buf_done, buf_irq, busy, busy_irq, overrun, crc_valid, crc_err;
  logic [7:0] m_data;

  int checks = 0, errors = 0;
  int n_bytes = 0, n_last = 0, n_done = 0, n_irq = 0, n_ovr = 0, n_crc = 0;
  logic [7:0] last_byte = '0;
  logic last_crc_err = 1'b0;
  bit finished = 0;

  always #4 clk = ~clk;

  xparent_rx dut (.*);

  always @(negedge clk) if (rst_n) begin
    if (m_valid) begin n_bytes++; last_byte = m_data; if (m_last) n_last++; end
    if (buf_done) n_done++;
    if (buf_irq) n_irq++;
    if (overrun) n_ovr++;
    if (crc_valid) begin n_crc++; last_crc_err = crc_err; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic p);
    @(negedge clk); bit_en = 1'b1; bit_in = b; sync_pulse = p;
    @(negedge clk); bit_en = 1'b0; sync_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b0);
  endtask

  task automatic send_pat(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) send_bit(v[i], 1'b0);
  endtask

  task automatic pulse_sig(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b,
                                          input logic [15:0] p);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ b[i];
      c = {c[14:0], 1'b0} ^ (fb ? p : 16'h0);
    end
    return c;
  endfunction

  task automatic t_reset;
    chk(!synced && !m_valid && !busy && !busy_irq && !overrun && !crc_valid, "R1 reset",
        {synced, m_valid, busy, busy_irq, overrun, crc_valid}, 0);
  endtask

  task automatic t_pattern;
    int b0;
    b0 = n_bytes;
    send_byte(8'h00); send_byte(8'hFF); send_byte(8'h00);
    chk(n_bytes == b0 && !synced, "R2 no data before pattern", n_bytes - b0, 0);
    send_pat(16'hA55A);
    chk(synced && n_bytes == b0, "R2 aligned, pattern not output", {synced, 8'(n_bytes - b0)}, 16'h100);
    send_byte(8'h3C);
    chk(n_bytes == b0 + 1 && last_byte == 8'h3C, "R4 first byte", last_byte, 8'h3C);
    send_byte(8'h81);
    chk(n_bytes == b0 + 2 && last_byte == 8'h81, "R4 second byte", last_byte, 8'h81);
  endtask

  task automatic t_reverse;
    int d0, i0;
    d0 = n_done; i0 = n_irq;
    reverse = 1'b1;
    send_byte(8'h12);
    chk(last_byte == 8'h48, "R5 mirror 12", last_byte, 8'h48);
    send_byte(8'hC1);
    chk(last_byte == 8'h83, "R5 mirror C1", last_byte, 8'h83);
    reverse = 1'b0;
    chk(n_done == d0 + 1 && n_irq == i0 + 1 && n_last == 1, "R7 fourth byte ends buffer, irq on",
        {n_done - d0, n_irq - i0}, 2);
  endtask

  task automatic t_hunt;
    int b0;
    pulse_sig(hunt_cmd);
    chk(!synced, "R6 hunt command drops sync", synced, 0);
    b0 = n_bytes;
    send_byte(8'h55);
    chk(n_bytes == b0 && !synced, "R6 no data while hunting", n_bytes - b0, 0);
    send_pat(16'hA55A);
    chk(synced, "R6 realigned", synced, 1);
  endtask

  task automatic t_buf_noirq;
    int d0, i0;
    d0 = n_done; i0 = n_irq;
    buf_irq_en = 1'b0;
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    chk(n_done == d0, "R7 no early completion", n_done - d0, 0);
    send_byte(8'h04);
    chk(n_done == d0 + 1 && n_irq == i0 && last_byte == 8'h04, "R7 completion, irq masked",
        {n_done - d0, n_irq - i0}, 16'h100);
    buf_irq_en = 1'b1;
  endtask

  task automatic t_busy;
    int b0;
    b0 = n_bytes;
    buf_avail = 1'b0;
    send_byte(8'h77);
    chk(busy && busy_irq && n_bytes == b0, "R8 busy set, byte dropped", {busy, busy_irq}, 3);
    send_byte(8'h78);
    chk(busy && n_bytes == b0, "R8 busy stays", busy, 1);
    busy_irq_en = 1'b0; @(negedge clk);
    chk(busy && !busy_irq, "R8 busy irq masked", busy_irq, 0);
    busy_irq_en = 1'b1;
    pulse_sig(busy_clr);
    chk(!busy && !busy_irq, "R8 busy cleared", busy, 0);
    buf_avail = 1'b1;
    send_byte(8'h99);
    chk(n_bytes == b0 + 1 && last_byte == 8'h99 && !busy, "R8 data resumes", last_byte, 8'h99);
  endtask

  task automatic t_overrun;
    int b0, o0;
    b0 = n_bytes; o0 = n_ovr;
    m_ready = 1'b0;
    send_byte(8'h3F);
    m_ready = 1'b1;
    chk(n_ovr == o0 + 1 && n_bytes == b0 && !synced, "R9 overrun forces hunt",
        {n_ovr - o0, 7'(n_bytes - b0), synced}, 16'h100);
  endtask

  task automatic t_ext;
    logic [7:0] v;
    int b0;
    v = 8'hB4; b0 = n_bytes;
    ext_mode = 1'b1;
    send_bit(v[7], 1'b1);
    chk(synced, "R3 pulse aligns", synced, 1);
    for (int i = 6; i >= 0; i--) send_bit(v[i], 1'b0);
    chk(n_bytes == b0 + 1 && last_byte == 8'hB4, "R3 pulse bit is data", last_byte, 8'hB4);
  endtask

  task automatic t_crc;
    logic [15:0] c, r;
    int c0;
    c0 = n_crc;
    pulse_sig(eof);
    chk(n_crc == c0 + 1 && last_crc_err == (crc_upd(16'h0, 8'hB4, 16'h1021) != 0),
        "R10 residual after B4", last_crc_err, 1);
    c = crc_upd(crc_upd(16'h0, 8'hD1, 16'h1021), 8'h2F, 16'h1021);
    send_byte(8'hD1); send_byte(8'h2F); send_byte(c[15:8]); send_byte(c[7:0]);
    pulse_sig(eof);
    chk(n_crc == c0 + 2 && !last_crc_err, "R10 good frame poly 1021", last_crc_err, 0);
    crc_sel = 1'b1;
    r = crc_upd(crc_upd(crc_upd(crc_upd(16'h0, 8'hD1, 16'h8005), 8'h2F, 16'h8005),
                c[15:8], 16'h8005), c[7:0], 16'h8005);
    send_byte(8'hD1); send_byte(8'h2F); send_byte(c[15:8]); send_byte(c[7:0]);
    pulse_sig(eof);
    chk(last_crc_err == (r != 0), "R10 wrong polynomial", last_crc_err, r != 0);
    c = crc_upd(crc_upd(16'h0, 8'h6A, 16'h8005), 8'hE3, 16'h8005);
    send_byte(8'h6A); send_byte(8'hE3); send_byte(c[15:8]); send_byte(c[7:0]);
    pulse_sig(eof);
    chk(n_crc == c0 + 4 && !last_crc_err, "R10 good frame poly 8005", last_crc_err, 0);
    crc_sel = 1'b0;
  endtask

  task automatic t_enable;
    int b0;
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(!synced, "R11 disable drops sync", synced, 1'b0);
    en = 1'b1; b0 = n_bytes;
    send_byte(8'hA5);
    chk(!synced && n_bytes == b0, "R11 stays in hunt without pulse", n_bytes - b0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    en = 1'b1;
    t_pattern;
    t_reverse;
    t_hunt;
    t_buf_noirq;
    t_busy;
    t_overrun;
    t_ext;
    t_crc;
    t_enable;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule